// File: doc/BRIEF.md
# Dual-Read Data Memory Address Decoder

This block sits between a processor core's data address generators and the data-side memories of a 16-bit address space. Each cycle it takes up to two read/write addresses: a primary address used by every ordinary access, and a secondary address that only the second read of a dual-read instruction drives. For each port it names the one region that serves the access. The regions are on-chip data RAM, on-chip data ROM, the on-chip peripheral register file, and external memory. It also gives the word offset inside that region, and it raises an error flag when the address falls on a location that nothing answers.

An expansion-mode input reshapes the primary map. With it clear, RAM sits at the bottom of the space and the peripherals sit at the top. A gap between the two on-chip arrays and the external window is unreachable. With it set, every primary access goes to external memory, except short I/O accesses to the top 64 words, which still reach the peripherals. The secondary port ignores the mode and the upper three address bits. It always lands in the 8192-word on-chip window, and it is the only path to the ROM. Results leave through one register stage.

Top module: `dmem_addr_decoder`

## Requirements
- R1: Outputs are registered: the select, index and error for an address appear on the first clock edge after it is presented. A port whose valid input is low yields select 0, index 0 and error 0, which is also the state held during reset.
- R2: The select vector is one-hot or zero. Bit 0 is data RAM, bit 1 is data ROM, bit 2 is peripherals and bit 3 is external memory. The error flag is set only when the select is zero, and then the index is 0.
- R3: Primary, mode clear: addresses 0x0000–0x0DFF select RAM with index equal to the address.
- R4: Primary, mode clear: addresses 0x0E00–0x1FFF (the ROM range and the hole) give error 1 and select nothing. The primary port never selects ROM.
- R5: Primary, mode clear: addresses 0xFF80–0xFFFF select peripherals with index = address − 0xFF80, whatever the short I/O flag.
- R6: Primary, mode clear: addresses 0x2000–0xFF7F select external memory with index equal to the address.
- R7: Primary, mode set: every address selects external memory with index equal to the address and never raises an error, except the case in R8.
- R8: Primary, mode set, short I/O flag set: addresses 0xFFC0–0xFFFF select peripherals with index = address − 0xFF80. Addresses 0xFF80–0xFFBF stay external.
- R9: Secondary: only address bits 12:0 are decoded, and the mode and short I/O inputs have no effect. Offsets 0x0000–0x0DFF select RAM with index equal to the offset.
- R10: Secondary: offsets 0x0E00–0x15FF select ROM with index = offset − 0x0E00.
- R11: Secondary: offsets 0x1600–0x1FFF give error 1 and select nothing. The secondary port never selects peripherals or external memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_mode | input | 1 | Expansion mode: primary map becomes external |
| pri_valid | input | 1 | Primary port access strobe |
| pri_addr | input | 16 | Primary address |
| pri_short_io | input | 1 | Primary access uses short I/O addressing |
| sec_valid | input | 1 | Secondary (dual-read) access strobe |
| sec_addr | input | 16 | Secondary address |
| pri_sel | output | 4 | Primary region select (RAM, ROM, peripheral, external) |
| pri_idx | output | 16 | Primary offset within the selected region |
| pri_err | output | 1 | Primary access hit an unreachable location |
| sec_sel | output | 4 | Secondary region select |
| sec_idx | output | 16 | Secondary offset within the selected region |
| sec_err | output | 1 | Secondary access hit the hole |

## Verification
The assertions compare each registered output with the inputs seen one edge earlier. They take for granted that reset is released synchronously to the clock, so that the inputs sampled on the edge after release were already stable. They also assume that no input changes close to the active edge. The bench drives every input on the falling edge and releases reset on one. The assertions assume nothing about address values, and the stimulus sweeps both ports over the whole space, including the region edges and high bits above the secondary window.

// File: rtl/dmem_dec_pkg.sv
package dmem_dec_pkg;
  localparam int ADDR_W = 16;
  localparam int REG_N  = 4;

  // Region select bit positions
  localparam int SEL_RAM = 0;
  localparam int SEL_ROM = 1;
  localparam int SEL_IO  = 2;
  localparam int SEL_EXT = 3;

  typedef logic [REG_N-1:0]  region_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    region_t sel;
    logic    err;
    addr_t   idx;
  } dec_res_t;
endpackage

// File: rtl/dmem_pri_decode.sv
module dmem_pri_decode
  import dmem_dec_pkg::*;
#(
  parameter int RAM_WORDS   = 3584,
  parameter int ROM_WORDS   = 2048,
  parameter int ONCHIP_W    = 13,
  parameter int IO_WORDS    = 128,
  parameter int IO_SH_WORDS = 64
) (
  input  logic     valid,
  input  addr_t    addr,
  input  logic     short_io,
  input  logic     ex_mode,
  output dec_res_t res
);
  localparam addr_t GAP_BASE = addr_t'(RAM_WORDS);
  localparam addr_t EXT_BASE = addr_t'(2 ** ONCHIP_W);
  localparam addr_t IO_BASE  = addr_t'((2 ** ADDR_W) - IO_WORDS);
  localparam addr_t SH_BASE  = addr_t'((2 ** ADDR_W) - IO_SH_WORDS);
  localparam int    UNUSED_ROM = ROM_WORDS;

  logic in_ram, in_gap, in_io, in_sh;

  always_comb begin
    in_ram = addr < GAP_BASE;
    in_gap = (addr >= GAP_BASE) && (addr < EXT_BASE);
    in_io  = addr >= IO_BASE;
    in_sh  = addr >= SH_BASE;
    res    = '0;
    if (valid) begin
      if (ex_mode) begin
        if (short_io && in_sh) begin
          res.sel[SEL_IO] = 1'b1;
          res.idx         = addr - IO_BASE;
        end else begin
          res.sel[SEL_EXT] = 1'b1;
          res.idx          = addr;
        end
      end else if (in_ram) begin
        res.sel[SEL_RAM] = 1'b1;
        res.idx          = addr;
      end else if (in_gap) begin
        // ROM range and hole are both unreachable from this port
        res.err = 1'b1;
      end else if (in_io) begin
        res.sel[SEL_IO] = 1'b1;
        res.idx         = addr - IO_BASE;
      end else begin
        res.sel[SEL_EXT] = 1'b1;
        res.idx          = addr;
      end
    end
  end
endmodule

// File: rtl/dmem_sec_decode.sv
module dmem_sec_decode
  import dmem_dec_pkg::*;
#(
  parameter int RAM_WORDS = 3584,
  parameter int ROM_WORDS = 2048,
  parameter int ONCHIP_W  = 13
) (
  input  logic     valid,
  input  addr_t    addr,
  output dec_res_t res
);
  localparam logic [ONCHIP_W-1:0] ROM_BASE  = ONCHIP_W'(RAM_WORDS);
  localparam logic [ONCHIP_W-1:0] HOLE_BASE = ONCHIP_W'(RAM_WORDS + ROM_WORDS);

  logic [ONCHIP_W-1:0] off;

  always_comb begin
    off = addr[ONCHIP_W-1:0];
    res = '0;
    if (valid) begin
      if (off < ROM_BASE) begin
        res.sel[SEL_RAM] = 1'b1;
        res.idx          = addr_t'(off);
      end else if (off < HOLE_BASE) begin
        res.sel[SEL_ROM] = 1'b1;
        res.idx          = addr_t'(off - ROM_BASE);
      end else begin
        res.err = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmem_dec_stage.sv
module dmem_dec_stage
  import dmem_dec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dec_res_t d,
  output dec_res_t q
);
  dec_res_t q_nxt;

  always_comb q_nxt = d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/dmem_addr_decoder.sv
module dmem_addr_decoder
  import dmem_dec_pkg::*;
#(
  parameter int RAM_WORDS   = 3584,
  parameter int ROM_WORDS   = 2048,
  parameter int ONCHIP_W    = 13,
  parameter int IO_WORDS    = 128,
  parameter int IO_SH_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_mode,
  input  logic              pri_valid,
  input  logic [ADDR_W-1:0] pri_addr,
  input  logic              pri_short_io,
  input  logic              sec_valid,
  input  logic [ADDR_W-1:0] sec_addr,
  output logic [REG_N-1:0]  pri_sel,
  output logic [ADDR_W-1:0] pri_idx,
  output logic              pri_err,
  output logic [REG_N-1:0]  sec_sel,
  output logic [ADDR_W-1:0] sec_idx,
  output logic              sec_err
);
  localparam int PORTS = 2;

  dec_res_t res_d [PORTS];
  dec_res_t res_q [PORTS];

  dmem_pri_decode #(
    .RAM_WORDS(RAM_WORDS), .ROM_WORDS(ROM_WORDS), .ONCHIP_W(ONCHIP_W),
    .IO_WORDS(IO_WORDS), .IO_SH_WORDS(IO_SH_WORDS)
  ) u_pri (
    .valid(pri_valid), .addr(pri_addr), .short_io(pri_short_io),
    .ex_mode(ex_mode), .res(res_d[0])
  );

  dmem_sec_decode #(
    .RAM_WORDS(RAM_WORDS), .ROM_WORDS(ROM_WORDS), .ONCHIP_W(ONCHIP_W)
  ) u_sec (
    .valid(sec_valid), .addr(sec_addr), .res(res_d[1])
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_stage
    dmem_dec_stage u_stage (
      .clk(clk), .rst_n(rst_n), .d(res_d[p]), .q(res_q[p])
    );
  end

  assign pri_sel = res_q[0].sel;
  assign pri_idx = res_q[0].idx;
  assign pri_err = res_q[0].err;
  assign sec_sel = res_q[1].sel;
  assign sec_idx = res_q[1].idx;
  assign sec_err = res_q[1].err;
endmodule

// File: rtl/dmem_dec_checker.sv
module dmem_dec_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ex_mode,
  input logic        pri_valid,
  input logic [15:0] pri_addr,
  input logic        pri_short_io,
  input logic        sec_valid,
  input logic [15:0] sec_addr,
  input logic [3:0]  pri_sel,
  input logic [15:0] pri_idx,
  input logic        pri_err,
  input logic [3:0]  sec_sel,
  input logic [15:0] sec_idx,
  input logic        sec_err
);
  // R1
  pri_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pri_valid) |-> (pri_sel == 4'd0 && !pri_err && pri_idx == 16'd0));

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pri_sel) && $onehot0(sec_sel));

  // R2
  err_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_err |-> (pri_sel == 4'd0 && pri_idx == 16'd0)) and
    (sec_err |-> (sec_sel == 4'd0 && sec_idx == 16'd0)));

  // R3
  pri_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && pri_valid && !ex_mode && pri_addr < 16'h0E00)
      |-> (pri_sel == 4'b0001 && pri_idx == $past(pri_addr)));

  // R4
  pri_no_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_sel[1]);

  // R7
  ex_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ex_mode && !pri_short_io) |-> (!pri_err && !pri_sel[0] && !pri_sel[2]));

  // R11
  sec_onchip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_sel[2] && !sec_sel[3]);

  // R11
  sec_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && sec_valid && sec_addr[12:0] >= 13'h1600) |-> sec_err);
endmodule

bind dmem_addr_decoder dmem_dec_checker chk_i (.*);

// File: tb/dmem_addr_decoder_tb_top.sv
module dmem_addr_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ex_mode, pri_valid, pri_short_io, sec_valid;
  logic [15:0] pri_addr, sec_addr;
  logic [3:0]  pri_sel, sec_sel;
  logic [15:0] pri_idx, sec_idx;
  logic        pri_err, sec_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int    q_sel[$];
  int    q_idx[$];
  int    q_err[$];
  string q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmem_addr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ex_mode(ex_mode),
    .pri_valid(pri_valid), .pri_addr(pri_addr), .pri_short_io(pri_short_io),
    .sec_valid(sec_valid), .sec_addr(sec_addr),
    .pri_sel(pri_sel), .pri_idx(pri_idx), .pri_err(pri_err),
    .sec_sel(sec_sel), .sec_idx(sec_idx), .sec_err(sec_err)
  );

  function automatic void model_pri(input bit v, input int a, input bit ex, input bit sio,
                                    output int sel, output int idx, output int err, output string tag);
    sel = 0; idx = 0; err = 0; tag = "R1";
    if (!v) return;
    if (ex) begin
      if (sio && a >= 'hFFC0) begin sel = 4; idx = a - 'hFF80; tag = "R8"; end
      else begin sel = 8; idx = a; tag = (sio && a >= 'hFF80) ? "R8" : "R7"; end
    end else if (a < 'h0E00) begin sel = 1; idx = a; tag = "R3"; end
    else if (a < 'h2000) begin err = 1; tag = "R4"; end
    else if (a >= 'hFF80) begin sel = 4; idx = a - 'hFF80; tag = "R5"; end
    else begin sel = 8; idx = a; tag = "R6"; end
  endfunction

  function automatic void model_sec(input bit v, input int a,
                                    output int sel, output int idx, output int err, output string tag);
    int off;
    sel = 0; idx = 0; err = 0; tag = "R1";
    if (!v) return;
    off = a % 8192;
    if (off < 'h0E00) begin sel = 1; idx = off; tag = "R9"; end
    else if (off < 'h1600) begin sel = 2; idx = off - 'h0E00; tag = "R10"; end
    else begin err = 1; tag = "R11"; end
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Compare outputs against the expectations pushed one cycle earlier
  task automatic compare();
    if (q_sel.size() < 2) return;
    chk(q_tag[0], "pri_sel", int'(pri_sel), q_sel[0]);
    chk(q_tag[0], "pri_idx", int'(pri_idx), q_idx[0]);
    chk(q_tag[0], "pri_err", int'(pri_err), q_err[0]);
    chk(q_tag[1], "sec_sel", int'(sec_sel), q_sel[1]);
    chk(q_tag[1], "sec_idx", int'(sec_idx), q_idx[1]);
    chk(q_tag[1], "sec_err", int'(sec_err), q_err[1]);
    void'(q_sel.pop_front()); void'(q_idx.pop_front());
    void'(q_err.pop_front()); void'(q_tag.pop_front());
    void'(q_sel.pop_front()); void'(q_idx.pop_front());
    void'(q_err.pop_front()); void'(q_tag.pop_front());
  endtask

  // Called at a falling edge: check last cycle, then drive next
  task automatic step(input bit ex, input bit pv, input int pa, input bit sio,
                      input bit sv, input int sa);
    int s, i, e;
    string t;
    compare();
    ex_mode = ex; pri_valid = pv; pri_addr = 16'(pa); pri_short_io = sio;
    sec_valid = sv; sec_addr = 16'(sa);
    model_pri(pv, pa, ex, sio, s, i, e, t);
    q_sel.push_back(s); q_idx.push_back(i); q_err.push_back(e); q_tag.push_back(t);
    model_sec(sv, sa, s, i, e, t);
    q_sel.push_back(s); q_idx.push_back(i); q_err.push_back(e); q_tag.push_back(t);
    @(negedge clk);
  endtask

  initial begin
    int edges [14];
    edges = '{'h0000, 'h0DFF, 'h0E00, 'h15FF, 'h1600, 'h1FFF, 'h2000,
              'hA000, 'hFF7F, 'hFF80, 'hFFBF, 'hFFC0, 'hFFFF, 'hF5FF};
    rst_n = 1'b0; ex_mode = 0; pri_valid = 1; pri_addr = 16'h0005;
    pri_short_io = 0; sec_valid = 1; sec_addr = 16'h0E01;
    repeat (3) @(negedge clk);
    // R1: reset state with active inputs
    chk("R1", "reset pri_sel", int'(pri_sel), 0);
    chk("R1", "reset sec_sel", int'(sec_sel), 0);
    chk("R1", "reset errs", int'({pri_err, sec_err}), 0);
    rst_n = 1'b1;
    // R1: idle ports
    step(0, 0, 'h0100, 0, 0, 'h0100);
    step(1, 0, 'hFFC0, 1, 0, 'h1600);
    // directed corners over every mode combination
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 14; k++) begin
        step(m[1], 1, edges[k], m[0], 1, edges[k]);
        step(m[1], 1, edges[k], m[0], 1, edges[13 - k] ^ 'hE000);
      end
    end
    // R9: secondary wraps modulo 8192, ignoring mode and short flag
    step(1, 1, 'h0000, 1, 1, 'hA000);
    step(0, 1, 'hFF80, 0, 1, 'h2E00);
    // random sweep
    for (int n = 0; n < 4000; n++) begin
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) != 0), $urandom_range(0, 65535),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) != 0), $urandom_range(0, 65535));
    end
    step(0, 0, 0, 0, 0, 0);
    compare();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule